// File: doc/BRIEF.md
# Spread-Spectrum Fractional Feedback Divider

This block drives the feedback path of a clock-multiplying loop. It divides the fast oscillator clock by an integer that it chooses again at the start of every divide cycle. When spreading is off, that integer is the programmed nominal divisor N. When spreading is on, the divisor is either N or N−1. The average ratio then drifts between N and N−1 along a slow triangular profile, so the loop output sweeps downward by one divisor step and back. This spreads the spectral energy of the clock over a narrow band instead of a single line.

Three pieces work in sequence, once per divide cycle:
- A phase counter walks through the programmed modulation period and produces a triangular target level.
- A first-order accumulator adds that level to its running residue and reports a carry each time the sum crosses half the period.
- A modulus counter takes N minus that carry as the length of its next cycle and emits a feedback clock.

The feedback clock is high for the first half of each cycle and low for the rest.

The divisor input is sampled only at the end of a divide cycle. A ratio change therefore never cuts a cycle short or stretches one.

Top module: `ssc_div_ctrl`

## Requirements
- R1: While reset is held, `div_cur` reads the default divisor 100 and `fb_clk` is low. The profile phase and the accumulator residue are both zero. After release, the first clock edge starts a new divide cycle.
- R2: Each divide cycle lasts exactly as many oscillator clocks as the `div_cur` value that cycle started with. The interval between consecutive rising edges of `fb_clk` is that value.
- R3: Within a cycle of length D, `fb_clk` is high for the first floor(D/2) clocks and low for the remaining clocks. It has exactly one rising edge per cycle, at the cycle start.
- R4: Spreading is inactive when `spread_en` is low or `mod_period` is below 2. While inactive, every new cycle uses `div_nominal` unchanged, and the profile phase and residue are held at zero.
- R5: While spreading is active, each issued divisor is `div_nominal` or `div_nominal` − 1 and nothing else.
- R6: Let k be the index of a divide cycle within the modulation period, with 0 ≤ k < P = `mod_period` and H = floor(P/2). The target level is k while k < H. Otherwise it is P − k, limited to at most H. The index k advances by one per cycle and wraps from P−1 to 0.
- R7: At each cycle boundary, the level is added to the residue. If the sum is at least H, the next divisor is N−1 and the residue becomes sum − H. Otherwise the next divisor is N and the residue becomes the sum.
- R8: Take any even P, with spreading enabled from the start. The mean divisor over the first P divide cycles is N − 0.5, within 0.01. For P=8 and N=10, every period issues the sequence 10,10,10,9,9,9,10,9.
- R9: `div_cur` changes only at a cycle boundary. A change of `div_nominal` in mid-cycle leaves the running cycle untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| spread_en | input | 1 | Turns the downward spreading on |
| div_nominal | input | DIV_W (8) | Nominal divisor N; must be at least 3 |
| mod_period | input | PER_W (16) | Modulation period in divide cycles |
| fb_clk | output | 1 | Divided feedback clock |
| div_cur | output | DIV_W (8) | Divisor of the divide cycle in progress |

## Verification
The spreading function is exercised with four profiles:
- A long even period at N=100 shows that the triangle and the accumulator together produce the half-step average.
- A short period of 8 at N=10 gives a divisor sequence that can be checked term by term. It separates a correct first-order carry from a plain toggle or an off-by-one in the ramp.
- An odd period checks the limit placed on the falling ramp.
- Disabling, and a period below 2, show that the divisor collapses to N.

A mid-cycle change of N separates loading at the terminal count from loading at once. The behavioural model, which uses cumulative sums rather than a residue, checks the feedback level and the divisor on every clock throughout all of these runs.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int SSC_DIV_W   = 8;
  localparam int SSC_PER_W   = 16;
  localparam int SSC_DIV_DEF = 100;
endpackage

// File: rtl/ssc_profile.sv
// Triangular target generator, stepped once per divide cycle.
module ssc_profile #(
  parameter int PER_W = ssc_pkg::SSC_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] level,
  output logic [PER_W-1:0] half
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] ph_q, ph_d, ph_inc, fall;

  assign half   = period >> 1;
  assign ph_inc = ph_q + ONE;

  always_comb begin
    fall = '0;
    if (ph_q < half) begin
      level = ph_q;
    end else if (ph_q < period) begin
      fall  = period - ph_q;
      level = (fall > half) ? half : fall;
    end else begin
      level = '0;
    end
  end

  always_comb begin
    ph_d = ph_q;
    if (!active) begin
      ph_d = '0;
    end else if (adv) begin
      ph_d = (ph_inc >= period) ? '0 : ph_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/ssc_dsm.sv
// First-order accumulator: carry when residue + level reaches half.
module ssc_dsm #(
  parameter int PER_W = ssc_pkg::SSC_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             active,
  input  logic [PER_W-1:0] level,
  input  logic [PER_W-1:0] half,
  output logic             carry
);
  logic [PER_W-1:0] acc_q, acc_d;
  logic [PER_W:0]   sum, wrapped;

  assign sum     = {1'b0, acc_q} + {1'b0, level};
  assign wrapped = sum - {1'b0, half};
  assign carry   = active && (sum >= {1'b0, half});

  always_comb begin
    acc_d = acc_q;
    if (!active) begin
      acc_d = '0;
    end else if (adv) begin
      acc_d = carry ? wrapped[PER_W-1:0] : sum[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/ssc_modcnt.sv
// Multi-modulus down counter; loads a new divisor only at terminal count.
module ssc_modcnt #(
  parameter int DIV_W   = ssc_pkg::SSC_DIV_W,
  parameter int DIV_DEF = ssc_pkg::SSC_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_load,
  output logic             tc,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] div_cur,
  output logic             fb_clk
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d;
  logic             fb_q, fb_d;

  assign tc      = (cnt_q == '0);
  assign cnt     = cnt_q;
  assign div_cur = div_q;
  assign fb_clk  = fb_q;

  always_comb begin
    if (tc) begin
      cnt_d = div_load - ONE;
      div_d = div_load;
    end else begin
      cnt_d = cnt_q - ONE;
      div_d = div_q;
    end
    fb_d = (cnt_d >= (div_d - (div_d >> 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= DIV_W'(DIV_DEF);
      fb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      fb_q  <= fb_d;
    end
  end
endmodule

// File: rtl/ssc_div_ctrl.sv
module ssc_div_ctrl #(
  parameter int DIV_W   = ssc_pkg::SSC_DIV_W,
  parameter int PER_W   = ssc_pkg::SSC_PER_W,
  parameter int DIV_DEF = ssc_pkg::SSC_DIV_DEF
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             spread_en,
  input  logic [DIV_W-1:0] div_nominal,
  input  logic [PER_W-1:0] mod_period,
  output logic             fb_clk,
  output logic [DIV_W-1:0] div_cur
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic             tc, active, carry;
  logic [DIV_W-1:0] cnt, div_issue;
  logic [PER_W-1:0] level, half;

  assign active    = spread_en && (mod_period >= MIN_PER);
  assign div_issue = div_nominal - {{(DIV_W-1){1'b0}}, carry};

  ssc_profile #(.PER_W(PER_W)) u_prof (
    .clk(clk_osc), .rst_n(rst_n), .adv(tc), .active(active),
    .period(mod_period), .level(level), .half(half)
  );

  ssc_dsm #(.PER_W(PER_W)) u_dsm (
    .clk(clk_osc), .rst_n(rst_n), .adv(tc), .active(active),
    .level(level), .half(half), .carry(carry)
  );

  ssc_modcnt #(.DIV_W(DIV_W), .DIV_DEF(DIV_DEF)) u_cnt (
    .clk(clk_osc), .rst_n(rst_n), .div_load(div_issue),
    .tc(tc), .cnt(cnt), .div_cur(div_cur), .fb_clk(fb_clk)
  );
endmodule

// File: rtl/ssc_div_ctrl_chk.sv
module ssc_div_ctrl_chk #(
  parameter int DIV_W = ssc_pkg::SSC_DIV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spread_en,
  input logic [DIV_W-1:0] div_nominal,
  input logic             fb_clk,
  input logic [DIV_W-1:0] div_cur,
  input logic             tc,
  input logic [DIV_W-1:0] cnt
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(div_cur)); // R9

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (div_cur == $past(div_nominal) || div_cur == $past(div_nominal) - ONE)); // R5

  AST_SPREAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !spread_en) |=> (div_cur == $past(div_nominal))); // R4

  AST_FB_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_clk) |-> $past(tc)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_cur); // R2
endmodule

bind ssc_div_ctrl ssc_div_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk_osc), .rst_n(rst_n), .spread_en(spread_en),
  .div_nominal(div_nominal), .fb_clk(fb_clk), .div_cur(div_cur),
  .tc(tc), .cnt(cnt)
);

// File: tb/tb_ssc_div_ctrl.sv
module tb_ssc_div_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        spread_en;
  logic [7:0]  div_nom;
  logic [15:0] mod_per;
  logic        fb;
  logic [7:0]  divc;

  always #10 clk = ~clk;

  ssc_div_ctrl dut (
    .clk_osc(clk), .rst_n(rst_n), .spread_en(spread_en),
    .div_nominal(div_nom), .mod_period(mod_per),
    .fb_clk(fb), .div_cur(divc)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Behavioural reference: position within cycle, cumulative level sum.
  int     m_pos, m_D, m_k, m_P, m_H, m_lev, m_dn;
  longint m_T;
  bit     m_act;

  function automatic int tri_lvl(input int k, input int p);
    int h, v;
    h = p / 2;
    if (k < h) return k;
    v = p - k;
    if (v < 0) v = 0;
    return (v > h) ? h : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_D = 100; m_pos = 99; m_k = 0; m_T = 0;
    end else begin
      m_P   = mod_per;
      m_H   = m_P / 2;
      m_act = spread_en && (m_P >= 2);
      if (m_pos == m_D - 1) begin
        m_lev = tri_lvl(m_k, m_P);
        m_dn  = 0;
        if (m_act && (((m_T + m_lev) / m_H) > (m_T / m_H))) m_dn = 1;
        m_D   = div_nom - m_dn;
        m_pos = 0;
        if (m_act) begin
          m_T = m_T + m_lev;
          m_k = (m_k + 1 >= m_P) ? 0 : m_k + 1;
        end
      end else begin
        m_pos++;
      end
      if (!m_act) begin m_k = 0; m_T = 0; end
    end
  end

  // Per-clock comparison against the model (R3, R6, R7).
  always @(negedge clk) begin
    if (rst_n) begin
      chk(divc == m_D, "R6/R7 divisor vs model", divc, m_D);
      chk(fb == (m_pos < m_D / 2), "R3 fb level vs model", fb, (m_pos < m_D / 2));
    end
  end

  // Cycle monitor: records divisor at each fb rise and checks cycle length (R2).
  int  seen[$];
  bit  fb_prev, started;
  int  len, cyc_div;
  always @(negedge clk) begin
    if (!rst_n) begin
      seen.delete(); fb_prev = 0; started = 0; len = 0;
    end else begin
      if (fb && !fb_prev) begin
        if (started) chk(len == cyc_div, "R2 cycle length", len, cyc_div);
        started = 1; len = 1; cyc_div = divc;
        seen.push_back(divc);
      end else begin
        len++;
      end
      fb_prev = fb;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    longint sum;
    int     bad, base, held;
    int     exp8[8] = '{10, 10, 10, 9, 9, 9, 10, 9};

    rst_n = 1'b0; spread_en = 1'b1; div_nom = 8'd100; mod_per = 16'd320;
    repeat (3) @(negedge clk);
    chk(divc == 8'd100, "R1 reset divisor", divc, 100);
    chk(fb == 1'b0, "R1 reset fb low", fb, 0);
    rst_n = 1'b1;

    // Long even period: mean and range.
    while (seen.size() < 320) @(negedge clk);
    sum = 0; bad = 0;
    for (int i = 0; i < 320; i++) begin
      sum += seen[i];
      if (seen[i] != 100 && seen[i] != 99) bad++;
    end
    chk((sum * 100 >= 3184000 - 320) && (sum * 100 <= 3184000 + 320),
        "R8 mean over period x320", sum, 31840);
    chk(bad == 0, "R5 divisor in {N-1,N}", bad, 0);
    chk(seen[0] == 100, "R1 first cycle after reset uses N", seen[0], 100);

    // Mid-cycle change of N.
    @(negedge clk);
    while (fb) @(negedge clk);
    repeat (3) @(negedge clk);
    held = divc;
    div_nom = 8'd60;
    @(negedge clk);
    chk(divc == held, "R9 no mid-cycle reload", divc, held);
    repeat (1500) @(negedge clk);
    bad = 0;
    for (int i = seen.size() - 5; i < seen.size(); i++)
      if (seen[i] != 60 && seen[i] != 59) bad++;
    chk(bad == 0, "R9 new N used after boundary", bad, 0);

    // Spreading disabled.
    spread_en = 1'b0; div_nom = 8'd80;
    repeat (200) @(negedge clk);
    base = seen.size();
    repeat (2000) @(negedge clk);
    bad = 0;
    for (int i = base; i < seen.size(); i++) if (seen[i] != 80) bad++;
    chk(bad == 0 && seen.size() > base, "R4 disabled holds N", bad, 0);

    // Period below 2 with enable set.
    spread_en = 1'b1; mod_per = 16'd1;
    repeat (200) @(negedge clk);
    base = seen.size();
    repeat (2000) @(negedge clk);
    bad = 0;
    for (int i = base; i < seen.size(); i++) if (seen[i] != 80) bad++;
    chk(bad == 0 && seen.size() > base, "R4 short period holds N", bad, 0);

    // Short period, exact sequence.
    rst_n = 1'b0; div_nom = 8'd10; mod_per = 16'd8; spread_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (seen.size() < 32) @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(seen[i] == exp8[i], "R6/R7 sequence P=8", seen[i], exp8[i]);
    for (int p = 1; p < 4; p++) begin
      sum = 0;
      for (int i = 0; i < 8; i++) sum += seen[p*8 + i];
      chk(sum == 76, "R8 period sum P=8", sum, 76);
    end

    // Odd period, restarted through a disable.
    spread_en = 1'b0;
    @(negedge clk);
    mod_per = 16'd7; spread_en = 1'b1;
    repeat (7 * 10 * 4) @(negedge clk);

    report();
  end
endmodule